// File: doc/BRIEF.md
# Staged-Update Programmable Clock Divider

This block derives an output clock from its input clock by a programmed ratio. The ratio is the sum of a high-phase count and a low-phase count held in one configuration word. An edge-select flag lets odd ratios keep a duty cycle close to half: it stretches the end of the high phase by half an input cycle. A bypass flag passes the input clock straight through.

Software reaches the block through a small write/read register port. A configuration write whose hold flag is set only stages the word. A write with the hold flag clear stages the word and applies it as well. Each application drops a lock flag for a fixed window while the phase counter restarts from zero. The lock flag then rises, and the first output period begins with its high phase.

Top module: `clkdiv_stage`

## Requirements
- R1: After reset the configuration word reads 0x0000_2000 (bypass only), the status word reads 0x0000_0001 (locked), and the output follows the input clock.
- R2: The configuration word (word address 0) is laid out as follows: low count in bits [5:0], high count in bits [11:6], edge select in bit 12, bypass in bit 13, and hold in bit 14. A read returns the last written bits [14:0], with bits [31:15] reading 0. A write with bit 14 set changes neither the output nor the lock flag.
- R3: A configuration write with bit 14 clear applies the written settings. The lock flag (status bit 0) reads 0 from the cycle after that write for exactly 16 input cycles and reads 1 after that.
- R4: With edge select 0 and equal counts H = L, the output is high for H input cycles and low for L input cycles, repeating every H+L cycles.
- R5: With edge select 1, the output rises on a rising input edge and falls on the falling input edge that follows the end of H high cycles. The high time is therefore H+0.5 cycles and the low time is L-0.5 cycles (for example, 2.5/2.5 at H=2, L=3).
- R6: With edge select 0 and unequal counts, the output is high for H cycles and low for L cycles, with no half-cycle shift.
- R7: With bypass set, the output equals the input clock, including during the lock window.
- R8: While the lock flag is low and bypass is clear, the output stays low. The first period after the lock flag rises starts with its high phase.
- R9: An applying write that arrives while a lock window is still running restarts the window, so the lock flag stays low for a full 16 cycles after the later write.
- R10: With a high count of 0 and bypass clear, the output stays low.
- R11: The status word (word address 1) has every bit other than bit 0 read as 0. Writes to the status address do not change the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 2 | Word address: 0 configuration, 1 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_out | output | 1 | Divided (or bypassed) output clock |

## Verification
The functions that can coincide are an applying write and a lock countdown already in progress from an earlier application. On that edge, the counter restart, the lock reload and the pending release all compete. The bench provokes this with a second applying write five cycles into the first window, using a different ratio and edge mode. It then judges that the lock flag stays low for the full window measured from the second write, and that the first output period after release follows the second configuration half-cycle by half-cycle.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

   // field geometry of the configuration word; software decodes these positions
   localparam int unsigned CDV_CNT_W    = 6;
   localparam int unsigned CDV_LO_LSB   = 0;
   localparam int unsigned CDV_HI_LSB   = CDV_CNT_W;
   localparam int unsigned CDV_EDGE_BIT = 2 * CDV_CNT_W;
   localparam int unsigned CDV_BYP_BIT  = 2 * CDV_CNT_W + 1;
   localparam int unsigned CDV_HOLD_BIT = 2 * CDV_CNT_W + 2;
   localparam int unsigned CDV_CFG_W    = 2 * CDV_CNT_W + 3;

   typedef struct packed {
      logic                 byp;
      logic                 half_ext;
      logic [CDV_CNT_W-1:0] hi;
      logic [CDV_CNT_W-1:0] lo;
   } cdv_cfg_t;

   localparam logic [CDV_CFG_W-1:0] CDV_RST_WORD = CDV_CFG_W'(1) << CDV_BYP_BIT;

   function automatic cdv_cfg_t cdv_unpack(input logic [CDV_CFG_W-1:0] w);
      cdv_cfg_t c;
      c.lo       = w[CDV_LO_LSB +: CDV_CNT_W];
      c.hi       = w[CDV_HI_LSB +: CDV_CNT_W];
      c.half_ext = w[CDV_EDGE_BIT];
      c.byp      = w[CDV_BYP_BIT];
      return c;
   endfunction

endpackage

// File: rtl/cdv_regs.sv
module cdv_regs
   import cdv_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LOCK_CYCLES = 16,
   parameter int unsigned CFG_ADDR    = 0,
   parameter int unsigned STAT_ADDR   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output cdv_cfg_t          act_o,
   output logic              apply_o,
   output logic              hold_o,
   output logic              release_o
);

   localparam int unsigned LOCK_W = $clog2(LOCK_CYCLES + 1);

   initial begin
      assert (DATA_W > CDV_CFG_W) else $error("cdv_regs: DATA_W too narrow");
      assert (LOCK_CYCLES >= 1) else $error("cdv_regs: LOCK_CYCLES must be >= 1");
      assert (CFG_ADDR != STAT_ADDR) else $error("cdv_regs: address clash");
   end

   logic [CDV_CFG_W-1:0] shadow_q;
   cdv_cfg_t             act_q;
   logic [LOCK_W-1:0]    lock_q;
   logic                 wr_cfg;
   logic                 wr_stat;
   logic                 apply;
   logic                 locked;
   logic                 unused_wbits;

   assign wr_cfg       = we && (addr == ADDR_W'(CFG_ADDR));
   assign wr_stat      = we && (addr == ADDR_W'(STAT_ADDR));
   assign apply        = wr_cfg && !wdata[CDV_HOLD_BIT];
   assign locked       = (lock_q == '0);
   assign unused_wbits = ^wdata[DATA_W-1:CDV_CFG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= CDV_RST_WORD;
         act_q    <= cdv_unpack(CDV_RST_WORD);
         lock_q   <= '0;
      end else begin
         if (wr_cfg) begin
            shadow_q <= wdata[CDV_CFG_W-1:0];
         end
         if (apply) begin
            act_q  <= cdv_unpack(wdata[CDV_CFG_W-1:0]);
            lock_q <= LOCK_W'(LOCK_CYCLES);
         end else if (!locked) begin
            lock_q <= lock_q - LOCK_W'(1);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CFG_ADDR)) begin
         rdata[CDV_CFG_W-1:0] = shadow_q;
      end else if (addr == ADDR_W'(STAT_ADDR)) begin
         rdata[0] = locked;
      end
   end

   assign act_o     = act_q;
   assign apply_o   = apply;
   assign hold_o    = !locked;
   assign release_o = (lock_q == LOCK_W'(1));

   // R3
   apply_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> !locked);

   // R3
   lock_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply && locked) |=> locked);

   // R9
   lock_window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q <= LOCK_W'(LOCK_CYCLES));

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cfg |=> (shadow_q == $past(wdata[CDV_CFG_W-1:0])));

   // R11
   status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> $stable(shadow_q));

endmodule

// File: rtl/cdv_core.sv
module cdv_core
   import cdv_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  cdv_cfg_t cfg,
   input  logic     restart_i,
   input  logic     hold_i,
   input  logic     release_i,
   output logic     div_o
);

   localparam int unsigned RW = CDV_CNT_W + 1;

   logic [RW-1:0] ratio;
   logic [RW-1:0] hi_ext;
   logic [RW-1:0] cnt_q;
   logic [RW-1:0] cnt_inc;
   logic [RW-1:0] cnt_nxt;
   logic          wrap;
   logic          out_q;

   assign hi_ext  = RW'(cfg.hi);
   assign ratio   = RW'(cfg.hi) + RW'(cfg.lo);
   assign cnt_inc = cnt_q + RW'(1);
   assign wrap    = (cnt_inc >= ratio);
   assign cnt_nxt = wrap ? '0 : cnt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q <= '0;
         out_q <= 1'b0;
      end else if (hold_i) begin
         cnt_q <= '0;
         out_q <= release_i && (hi_ext != '0);
      end else begin
         cnt_q <= cnt_nxt;
         out_q <= (cnt_nxt < hi_ext);
      end
   end

   assign div_o = out_q;

   // R8
   quiet_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |-> !out_q);

   // R4
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio != '0) |-> (cnt_q < ratio));

   // R10
   no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.hi == '0) |-> !out_q);

endmodule

// File: rtl/cdv_halfext.sv
module cdv_halfext (
   input  logic clk,
   input  logic rst_n,
   input  logic div_i,
   input  logic en_i,
   output logic wave_o
);

   logic fall_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_q <= 1'b0;
      end else begin
         fall_q <= div_i && en_i;
      end
   end

   assign wave_o = div_i | fall_q;

   // R6
   no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !fall_q);

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
   import cdv_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LOCK_CYCLES = 16,
   parameter bit          EDGE_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              clk_out
);

   localparam int unsigned CFG_ADDR  = 0;
   localparam int unsigned STAT_ADDR = 1;

   initial begin
      assert (ADDR_W >= 1) else $error("clkdiv_stage: ADDR_W must be >= 1");
      assert ((1 << ADDR_W) > STAT_ADDR) else $error("clkdiv_stage: ADDR_W too narrow");
   end

   cdv_cfg_t act;
   logic     apply;
   logic     hold;
   logic     rel;
   logic     div;
   logic     wave;

   cdv_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .LOCK_CYCLES (LOCK_CYCLES),
      .CFG_ADDR    (CFG_ADDR),
      .STAT_ADDR   (STAT_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .act_o     (act),
      .apply_o   (apply),
      .hold_o    (hold),
      .release_o (rel)
   );

   cdv_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (act),
      .restart_i (apply),
      .hold_i    (hold),
      .release_i (rel),
      .div_o     (div)
   );

   generate
      if (EDGE_EN) begin : g_half
         cdv_halfext u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .div_i  (div),
            .en_i   (act.half_ext),
            .wave_o (wave)
         );
      end else begin : g_plain
         assign wave = div;
      end
   endgenerate

   assign clk_out = act.byp ? clk : wave;

endmodule

// File: tb/clkdiv_stage_bench.sv
module clkdiv_stage_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        clk_out;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   clkdiv_stage u_clkdiv_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .clk_out   (clk_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // returns one time unit after the capturing rising edge
   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(posedge clk);
      #1;
      bus_we    = 1'b0;
      bus_wdata = 32'd0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic rise_at(input int c, input int hi, input int lo);
      int n;
      n = hi + lo;
      if (c < 0 || n == 0) return 1'b0;
      return ((c % n) < hi);
   endfunction

   // apply a word, check the lock window and two output periods after release
   task automatic apply_meas(input logic [31:0] word, input int hi, input int lo,
                             input bit ext, input bit byp,
                             input string lock_tag, input string wave_tag);
      logic [31:0] d;
      logic        e;
      bus_wr(2'd0, word);
      bus_rd(2'd1, d);
      chk({lock_tag, " lock low after apply"}, d, 32'd0);
      for (int i = 1; i < 16; i++) begin
         @(posedge clk);
         #1;
         if (!byp) chk("R8 output quiet during lock", {31'd0, clk_out}, 32'd0);
         bus_rd(2'd1, d);
         chk({lock_tag, " lock still low"}, d, 32'd0);
      end
      @(posedge clk);
      #1;
      // first half of cycle 0 of the new period
      for (int c = 0; c < 2 * (hi + lo); c++) begin
         if (c != 0) begin
            @(posedge clk);
            #1;
         end
         if (byp) e = 1'b1;
         else if (ext) e = rise_at(c, hi, lo) | rise_at(c - 1, hi, lo);
         else e = rise_at(c, hi, lo);
         chk({wave_tag, " first half"}, {31'd0, clk_out}, {31'd0, e});
         if (c == 0) begin
            bus_rd(2'd1, d);
            chk({lock_tag, " lock high after window"}, d, 32'd1);
         end
         @(negedge clk);
         #1;
         e = byp ? 1'b0 : rise_at(c, hi, lo);
         chk({wave_tag, " second half"}, {31'd0, clk_out}, {31'd0, e});
      end
      bus_rd(2'd0, d);
      chk("R2 readback after apply", d, word & 32'h0000_7FFF);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      bus_rd(2'd0, d);
      chk("R1 config reset value", d, 32'h0000_2000);
      bus_rd(2'd1, d);
      chk("R1 status reset value", d, 32'h0000_0001);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #1;
         chk("R1 bypass high half", {31'd0, clk_out}, 32'd1);
         @(negedge clk);
         #1;
         chk("R1 bypass low half", {31'd0, clk_out}, 32'd0);
      end
   endtask

   task automatic t_stage;
      logic [31:0] d;
      bus_wr(2'd0, 32'hFFFF_6083);
      bus_rd(2'd0, d);
      chk("R2 staged readback masks upper bits", d, 32'h0000_6083);
      for (int i = 0; i < 4; i++) begin
         bus_rd(2'd1, d);
         chk("R2 staging keeps lock", d, 32'd1);
         @(negedge clk);
         #1;
         chk("R2 staging keeps output low half", {31'd0, clk_out}, 32'd0);
         @(posedge clk);
         #1;
         chk("R2 staging keeps output high half", {31'd0, clk_out}, 32'd1);
      end
   endtask

   task automatic t_status_ro;
      logic [31:0] d;
      bus_wr(2'd1, 32'hFFFF_FFFF);
      bus_rd(2'd0, d);
      chk("R11 config unchanged by status write", d, 32'h0000_6083);
      bus_rd(2'd1, d);
      chk("R11 status upper bits zero", d, 32'h0000_0001);
   endtask

   task automatic t_even;
      apply_meas(32'h0000_0082, 2, 2, 1'b0, 1'b0, "R3", "R4 even ratio 4");
   endtask

   task automatic t_odd_ext;
      apply_meas(32'h0000_1083, 2, 3, 1'b1, 1'b0, "R3", "R5 odd ratio 5 stretched");
   endtask

   task automatic t_odd_plain;
      apply_meas(32'h0000_0083, 2, 3, 1'b0, 1'b0, "R3", "R6 odd ratio 5 unstretched");
   endtask

   task automatic t_restart;
      bus_wr(2'd0, 32'h0000_0082);
      repeat (5) @(posedge clk);
      #1;
      apply_meas(32'h0000_1041, 1, 1, 1'b1, 1'b0, "R9", "R9 config after restarted window");
   endtask

   task automatic t_zero_high;
      apply_meas(32'h0000_0003, 0, 3, 1'b0, 1'b0, "R3", "R10 zero high count");
   endtask

   task automatic t_bypass;
      apply_meas(32'h0000_2000, 0, 1, 1'b0, 1'b1, "R3", "R7 bypass follows clock");
   endtask

   initial begin
      #(8 * 20000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stage();
      t_status_ro();
      t_even();
      t_odd_ext();
      t_odd_plain();
      t_restart();
      t_zero_high();
      t_bypass();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule